// File: doc/BRIEF.md
# Configuration Access Port Bridge

This block sits on the host side of a peripheral bus and turns processor I/O-space accesses into configuration transactions. Software first writes a dword address latch that names a bus, a device, a function and a dword register index, with a top enable bit. It then reads or writes a dword data window. When the enable bit is set, a data-window access becomes one configuration request on the bus side. That request carries the generated command code, the byte lanes, the write data and an even parity bit.

A zero bus number selects a local (type 0) request: one address line, chosen by the device number, is raised as the device select. Any other bus number produces a forwarding (type 1) request that carries all of the latched fields. Data-window accesses with the enable bit clear, accesses to any other I/O address, and partial accesses to the latch are all sent out as ordinary I/O cycles. Only one request is in flight at a time. The host access stalls until the bus side reports a completion or a no-response timeout expires. Reads that no device claims return all ones.

Top module: `cfg_port_bridge`

## Requirements
- R1: A full dword write (io_size 2 or 3) to I/O address 0x0CF8 loads the address latch. A read of 0x0CF8 returns bit 31 (enable), bits 23:16 (bus), 15:11 (device), 10:8 (function) and 7:2 (register index) as written, with bits 30:24 and 1:0 read as zero. No bus request is issued for these accesses.
- R2: A byte or 16-bit access to 0x0CF8 leaves the latch unchanged and is sent out as an ordinary I/O cycle.
- R3: With the enable set, a data-window access (0x0CFC to 0x0CFF) issues a configuration read with command 4'b1010 or a configuration write with command 4'b1011. The active-high byte enables are 1111 for io_size 2 or 3, 0001<<io_addr[1:0] for io_size 0, and 0011<<(2*io_addr[1]) for io_size 1. Write data passes unchanged.
- R4: With bus 0, req_addr bits 31:11 hold a one-hot device select with bit 11+device set when device <= 20, and no bit set for device 21 to 31. Bits 10:8 hold the function, bits 7:2 the register index, and bits 1:0 are 00.
- R5: With a non-zero bus, req_addr = {8'h00, bus, device, function, register, 2'b01}.
- R6: Data-window accesses with the enable clear, and accesses to any other address, issue I/O read 4'b0010 or I/O write 4'b0011. The address is the 16-bit I/O address zero-extended, and the byte enables follow the R3 rule.
- R7: While req_valid is high, the total count of ones in req_addr, req_cmd and req_par is even.
- R8: req_valid and the request fields stay unchanged until completion or timeout. io_ready is then a one-cycle pulse.
- R9: A claimed read returns cpl_rdata. An unclaimed completion (cpl_claimed low) or a timeout returns 32'hFFFFFFFF.
- R10: A request that gets no completion ends after exactly TIMEOUT_CYCLES cycles of req_valid.
- R11: After reset, req_valid and io_ready are low and the address latch reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_valid | input | 1 | Host I/O access present, held until io_ready |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | Byte I/O address |
| io_size | input | 2 | 0 byte, 1 half, 2 or 3 dword |
| io_wdata | input | 32 | Host write data |
| io_ready | output | 1 | One-cycle completion pulse to the host |
| io_rdata | output | 32 | Read data, valid with io_ready |
| req_valid | output | 1 | Bus request outstanding |
| req_cmd | output | 4 | Bus command code |
| req_addr | output | 32 | Address-phase value |
| req_be | output | 4 | Active-high byte lane enables |
| req_wdata | output | 32 | Write data for the data phase |
| req_par | output | 1 | Even parity over req_addr and req_cmd |
| cpl_valid | input | 1 | Completion for the outstanding request |
| cpl_claimed | input | 1 | A target claimed the request |
| cpl_rdata | input | 32 | Read data from the target |

## Verification
The assertions assume that the host holds io_valid and its fields steady until it sees io_ready, and drops io_valid before the next clock edge. They also assume that cpl_valid is raised only while req_valid is high, and for one cycle only. The bench host task drives and releases io_valid on falling edges, following that pattern. The bench responder raises cpl_valid only after it has observed a live request, and clears it on the next falling edge. The silent responder mode never drives a completion, which lets the timeout path run.

// File: rtl/cfg_port_pkg.sv
// Package: shared command codes, states, latch field struct and lane-mask helper
// for the configuration access port bridge. Assumes a 32-bit address/data path.
package cfg_port_pkg;
    localparam int DWORD_W = 32;
    localparam int BE_W    = DWORD_W / 8;

    typedef enum logic [3:0] {
        CMD_IO_RD  = 4'b0010,
        CMD_IO_WR  = 4'b0011,
        CMD_CFG_RD = 4'b1010,
        CMD_CFG_WR = 4'b1011
    } bus_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } txn_state_e;

    typedef struct packed {
        logic       enable;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] func;
        logic [5:0] regno;
    } cfg_sel_t;

    // Byte lanes touched by an access of the given size at the given offset.
    function automatic logic [BE_W-1:0] lane_mask(input logic [1:0] size, input logic [1:0] off);
        logic [BE_W-1:0] m;
        case (size)
            2'd0:    m = 4'b0001 << off;
            2'd1:    m = off[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/cfg_addr_latch.sv
// Module: holds the configuration address latch. Loads on wr_en from a full
// dword; reserved bits are not stored and read back as zero.
// Assumes: wr_en is only raised for an accepted full-dword write to the latch.
module cfg_addr_latch
    import cfg_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DWORD_W-1:0] wdata,
    output cfg_sel_t           sel,
    output logic [DWORD_W-1:0] rd_value
);
    // Capture the enable and selection fields from the host dword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
        end else if (wr_en) begin
            sel <= {wdata[31], wdata[23:16], wdata[15:11], wdata[10:8], wdata[7:2]};
        end
    end

    // Present the stored fields in their dword positions for read-back.
    always_comb begin
        rd_value = {sel.enable, 7'b0, sel.bus, sel.dev, sel.func, sel.regno, 2'b00};
    end
endmodule

// File: rtl/cfg_req_build.sv
// Module: decodes a host I/O access and builds the bus request it maps to:
// command, address-phase value, byte lanes and even parity.
// Assumes: io_addr is a byte address; decode uses the dword part only.
module cfg_req_build
    import cfg_port_pkg::*;
#(
    parameter int              IO_AW       = 16,
    parameter logic [IO_AW-1:0] LATCH_IO   = 16'h0CF8,
    parameter logic [IO_AW-1:0] WINDOW_IO  = 16'h0CFC
) (
    input  cfg_sel_t           sel,
    input  logic               io_write,
    input  logic [IO_AW-1:0]   io_addr,
    input  logic [1:0]         io_size,
    output logic               is_local,
    output bus_cmd_e           b_cmd,
    output logic [DWORD_W-1:0] b_addr,
    output logic [BE_W-1:0]    b_be,
    output logic               b_par
);
    localparam int SEL_LO    = 11;
    localparam int SEL_LINES = DWORD_W - SEL_LO;

    logic                 hit_latch, hit_window, full_dw, is_cfg, type0;
    logic [SEL_LINES-1:0] dev_sel;

    // One decoder per device-select address line.
    for (genvar g = 0; g < SEL_LINES; g++) begin : g_dev_sel
        assign dev_sel[g] = (sel.dev == 5'(g));
    end

    // Address decode and classification of the access.
    always_comb begin
        hit_latch  = io_addr[IO_AW-1:2] == LATCH_IO[IO_AW-1:2];
        hit_window = io_addr[IO_AW-1:2] == WINDOW_IO[IO_AW-1:2];
        full_dw    = io_size[1];
        is_local   = hit_latch && full_dw;
        is_cfg     = hit_window && sel.enable;
        type0      = sel.bus == 8'd0;
    end

    // Command, address phase, lanes and parity for the outgoing request.
    always_comb begin
        if (is_cfg) begin
            b_cmd = io_write ? CMD_CFG_WR : CMD_CFG_RD;
            if (type0) begin
                b_addr = {dev_sel, sel.func, sel.regno, 2'b00};
            end else begin
                b_addr = {8'h00, sel.bus, sel.dev, sel.func, sel.regno, 2'b01};
            end
        end else begin
            b_cmd  = io_write ? CMD_IO_WR : CMD_IO_RD;
            b_addr = {{(DWORD_W-IO_AW){1'b0}}, io_addr};
        end
        b_be  = lane_mask(io_size, io_addr[1:0]);
        b_par = ^{b_addr, b_cmd};
    end
endmodule

// File: rtl/cfg_txn_ctrl.sv
// Module: sequences one host access at a time. Latch accesses finish locally;
// everything else becomes a held bus request that ends on completion or timeout.
// Assumes: host holds io_valid until io_ready and drops it before the next edge;
// cpl_valid is a single-cycle pulse raised only while req_valid is high.
module cfg_txn_ctrl
    import cfg_port_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_valid,
    input  logic               io_write,
    input  logic [DWORD_W-1:0] io_wdata,
    input  logic               is_local,
    input  logic [DWORD_W-1:0] local_rdata,
    input  bus_cmd_e           b_cmd,
    input  logic [DWORD_W-1:0] b_addr,
    input  logic [BE_W-1:0]    b_be,
    input  logic               b_par,
    input  logic               cpl_valid,
    input  logic               cpl_claimed,
    input  logic [DWORD_W-1:0] cpl_rdata,
    output logic               accept,
    output logic               io_ready,
    output logic [DWORD_W-1:0] io_rdata,
    output logic               req_valid,
    output bus_cmd_e           req_cmd,
    output logic [DWORD_W-1:0] req_addr,
    output logic [BE_W-1:0]    req_be,
    output logic [DWORD_W-1:0] req_wdata,
    output logic               req_par
);
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    txn_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             wr_q;

    // Decode of the current phase for the host and bus sides.
    always_comb begin
        accept    = (state == ST_IDLE) && io_valid;
        req_valid = (state == ST_WAIT);
        io_ready  = (state == ST_RESP);
    end

    // Transaction sequencer: capture, wait with timeout, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            wr_q      <= 1'b0;
            io_rdata  <= '0;
            req_cmd   <= CMD_IO_RD;
            req_addr  <= '0;
            req_be    <= '0;
            req_wdata <= '0;
            req_par   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (io_valid) begin
                        if (is_local) begin
                            io_rdata <= local_rdata;
                            state    <= ST_RESP;
                        end else begin
                            req_cmd   <= b_cmd;
                            req_addr  <= b_addr;
                            req_be    <= b_be;
                            req_wdata <= io_wdata;
                            req_par   <= b_par;
                            wr_q      <= io_write;
                            cnt       <= '0;
                            state     <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (cpl_valid) begin
                        io_rdata <= wr_q ? '0 : (cpl_claimed ? cpl_rdata : '1);
                        state    <= ST_RESP;
                    end else if (cnt == CNT_LAST) begin
                        io_rdata <= wr_q ? '0 : '1;
                        state    <= ST_RESP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: request held steady until completion or the last timeout cycle.
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !cpl_valid && cnt != CNT_LAST
        |=> req_valid && $stable(req_addr) && $stable(req_cmd) && $stable(req_be));

    // R8: host completion is a single-cycle pulse.
    a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        io_ready |=> !io_ready);

    // R7: even parity across address phase, command and parity bit.
    a_r7_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (^{req_addr, req_cmd, req_par}) == 1'b0);

    // R4: a local configuration request raises at most one device select line.
    a_r4_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_cmd[3] && req_addr[1:0] == 2'b00 |-> $onehot0(req_addr[31:11]));

    // R9: an unclaimed read completes with all ones.
    a_r9_unclaimed_ones: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cpl_valid && !cpl_claimed && !wr_q |=> io_ready && io_rdata == '1);

    // R10: timeout counter never passes its bound.
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);
endmodule

// File: rtl/cfg_port_bridge.sv
// Module: top of the configuration access port bridge. Connects the address
// latch, the request builder and the transaction sequencer.
// Assumes: a single host issuing one I/O access at a time.
module cfg_port_bridge
    import cfg_port_pkg::*;
#(
    parameter int               IO_AW          = 16,
    parameter logic [IO_AW-1:0] LATCH_IO       = 16'h0CF8,
    parameter logic [IO_AW-1:0] WINDOW_IO      = 16'h0CFC,
    parameter int               TIMEOUT_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_valid,
    input  logic             io_write,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [1:0]       io_size,
    input  logic [31:0]      io_wdata,
    output logic             io_ready,
    output logic [31:0]      io_rdata,
    output logic             req_valid,
    output logic [3:0]       req_cmd,
    output logic [31:0]      req_addr,
    output logic [3:0]       req_be,
    output logic [31:0]      req_wdata,
    output logic             req_par,
    input  logic             cpl_valid,
    input  logic             cpl_claimed,
    input  logic [31:0]      cpl_rdata
);
    cfg_sel_t           sel;
    logic [DWORD_W-1:0] latch_rd, b_addr;
    logic               is_local, accept, latch_we, b_par;
    logic [BE_W-1:0]    b_be;
    bus_cmd_e           b_cmd, cmd_q;

    // Latch loads only on an accepted full-dword write to its address.
    always_comb begin
        latch_we = accept && is_local && io_write;
        req_cmd  = cmd_q;
    end

    cfg_addr_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (latch_we),
        .wdata    (io_wdata),
        .sel      (sel),
        .rd_value (latch_rd)
    );

    cfg_req_build #(
        .IO_AW     (IO_AW),
        .LATCH_IO  (LATCH_IO),
        .WINDOW_IO (WINDOW_IO)
    ) u_build (
        .sel      (sel),
        .io_write (io_write),
        .io_addr  (io_addr),
        .io_size  (io_size),
        .is_local (is_local),
        .b_cmd    (b_cmd),
        .b_addr   (b_addr),
        .b_be     (b_be),
        .b_par    (b_par)
    );

    cfg_txn_ctrl #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_valid    (io_valid),
        .io_write    (io_write),
        .io_wdata    (io_wdata),
        .is_local    (is_local),
        .local_rdata (latch_rd),
        .b_cmd       (b_cmd),
        .b_addr      (b_addr),
        .b_be        (b_be),
        .b_par       (b_par),
        .cpl_valid   (cpl_valid),
        .cpl_claimed (cpl_claimed),
        .cpl_rdata   (cpl_rdata),
        .accept      (accept),
        .io_ready    (io_ready),
        .io_rdata    (io_rdata),
        .req_valid   (req_valid),
        .req_cmd     (cmd_q),
        .req_addr    (req_addr),
        .req_be      (req_be),
        .req_wdata   (req_wdata),
        .req_par     (req_par)
    );
endmodule

// File: tb/cfg_port_bridge_tb_top.sv
module cfg_port_bridge_tb_top;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0, io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic        io_ready, req_valid, req_par;
    logic [31:0] io_rdata, req_addr, req_wdata;
    logic [3:0]  req_cmd, req_be;
    logic        cpl_valid = 1'b0, cpl_claimed = 1'b0;
    logic [31:0] cpl_rdata = '0;

    int checks = 0, errors = 0, cycles = 0;

    // responder control and captured request
    int          resp_mode = 0;   // 0 claim, 1 unclaimed, 2 silent
    int          resp_delay = 1;
    logic [31:0] resp_data = '0;
    int          wait_cnt = 0, req_cycles = 0;
    logic        req_seen = 0, stab_err = 0;
    logic [3:0]  cap_cmd, cap_be;
    logic [31:0] cap_addr, cap_wdata;
    logic        cap_par;

    always #10 clk = ~clk;

    cfg_port_bridge #(.TIMEOUT_CYCLES(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
        .io_ready(io_ready), .io_rdata(io_rdata), .req_valid(req_valid),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .req_par(req_par), .cpl_valid(cpl_valid),
        .cpl_claimed(cpl_claimed), .cpl_rdata(cpl_rdata)
    );

    task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // bus-side responder model, acting on falling edges
    always @(negedge clk) begin
        if (cpl_valid) begin
            cpl_valid = 1'b0;
            wait_cnt = 0;
        end else if (req_valid) begin
            if (wait_cnt == 0) begin
                req_seen = 1; cap_cmd = req_cmd; cap_addr = req_addr;
                cap_be = req_be; cap_wdata = req_wdata; cap_par = req_par;
            end else if (req_addr != cap_addr || req_cmd != cap_cmd || req_be != cap_be) begin
                stab_err = 1;
            end
            req_cycles++;
            if (resp_mode != 2 && wait_cnt == resp_delay) begin
                cpl_valid = 1'b1;
                cpl_claimed = (resp_mode == 0);
                cpl_rdata = resp_data;
            end
            wait_cnt++;
        end else begin
            wait_cnt = 0;
        end
    end

    task automatic io_access(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                             input logic [31:0] wd, output logic [31:0] rd);
        logic done = 0;
        @(negedge clk);
        req_seen = 0; stab_err = 0; req_cycles = 0;
        io_valid = 1; io_write = wr; io_addr = a; io_size = sz; io_wdata = wd;
        rd = '0;
        while (!done) begin
            @(negedge clk);
            if (io_ready) begin
                rd = io_rdata; done = 1; io_valid = 0;
            end
        end
        @(negedge clk);
        chk(!io_ready, "R8 ready pulse", {31'b0, io_ready}, 32'h0);
        chk(!stab_err, "R8 request stable", {31'b0, stab_err}, 32'h0);
        if (req_seen)
            chk((^{cap_addr, cap_cmd, cap_par}) == 1'b0, "R7 parity", {31'b0, cap_par}, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] rd;
        chk(!req_valid, "R11 req_valid", {31'b0, req_valid}, 0);
        chk(!io_ready, "R11 io_ready", {31'b0, io_ready}, 0);
        io_access(0, 16'h0CF8, 2, 0, rd);
        chk(rd == 0, "R11 latch zero", rd, 0);
    endtask

    task automatic t_latch();
        logic [31:0] rd;
        io_access(1, 16'h0CF8, 2, 32'h7F00_0000, rd);
        io_access(0, 16'h0CF8, 2, 0, rd);
        chk(rd == 32'h0, "R1 reserved read zero", rd, 0);
        io_access(1, 16'h0CF8, 3, 32'hFF05_1A0F, rd);
        chk(!req_seen, "R1 no bus request", {31'b0, req_seen}, 0);
        io_access(0, 16'h0CF8, 2, 0, rd);
        chk(rd == 32'h8005_1A0C, "R1 readback", rd, 32'h8005_1A0C);
    endtask

    task automatic t_type1();
        logic [31:0] rd;
        resp_mode = 0; resp_delay = 2; resp_data = 32'hDEAD_BEEF;
        io_access(0, 16'h0CFC, 2, 0, rd);
        chk(cap_cmd == 4'b1010, "R3 cfg read cmd", {28'b0, cap_cmd}, 32'hA);
        chk(cap_addr == 32'h0005_1A0D, "R5 type1 addr", cap_addr, 32'h0005_1A0D);
        chk(cap_be == 4'b1111, "R3 dword lanes", {28'b0, cap_be}, 32'hF);
        chk(rd == 32'hDEAD_BEEF, "R9 claimed data", rd, 32'hDEAD_BEEF);
        io_access(1, 16'h0CFE, 0, 32'hA5A5_1234, rd);
        chk(cap_cmd == 4'b1011, "R3 cfg write cmd", {28'b0, cap_cmd}, 32'hB);
        chk(cap_be == 4'b0100, "R3 byte lane", {28'b0, cap_be}, 32'h4);
        chk(cap_wdata == 32'hA5A5_1234, "R3 wdata", cap_wdata, 32'hA5A5_1234);
    endtask

    task automatic t_type0();
        logic [31:0] rd;
        io_access(1, 16'h0CF8, 2, 32'h8000_2A10, rd);
        resp_mode = 1; resp_delay = 1;
        io_access(0, 16'h0CFE, 1, 0, rd);
        chk(cap_addr == 32'h0001_0210, "R4 type0 addr", cap_addr, 32'h0001_0210);
        chk(cap_be == 4'b1100, "R3 half lanes", {28'b0, cap_be}, 32'hC);
        chk(rd == 32'hFFFF_FFFF, "R9 unclaimed ones", rd, 32'hFFFF_FFFF);
    endtask

    task automatic t_timeout();
        logic [31:0] rd;
        io_access(1, 16'h0CF8, 2, 32'h8000_A800, rd);
        resp_mode = 2;
        io_access(0, 16'h0CFC, 2, 0, rd);
        chk(cap_addr == 32'h0, "R4 device 21 no select", cap_addr, 0);
        chk(req_cycles == TMO, "R10 timeout length", req_cycles, TMO);
        chk(rd == 32'hFFFF_FFFF, "R9 timeout ones", rd, 32'hFFFF_FFFF);
    endtask

    task automatic t_partial_latch();
        logic [31:0] rd;
        resp_mode = 0; resp_delay = 0;
        io_access(1, 16'h0CF8, 0, 32'h0, rd);
        chk(cap_cmd == 4'b0011, "R2 io write cmd", {28'b0, cap_cmd}, 32'h3);
        chk(cap_addr == 32'h0CF8 && cap_be == 4'b0001, "R2 io addr/lane", cap_addr, 32'h0CF8);
        io_access(0, 16'h0CF8, 2, 0, rd);
        chk(rd == 32'h8000_A800, "R2 latch unchanged", rd, 32'h8000_A800);
    endtask

    task automatic t_passthru();
        logic [31:0] rd;
        io_access(1, 16'h0CF8, 2, 32'h0000_2A10, rd);
        resp_mode = 0; resp_delay = 3; resp_data = 32'h1234_5678;
        io_access(0, 16'h0CFD, 0, 0, rd);
        chk(cap_cmd == 4'b0010, "R6 io read cmd", {28'b0, cap_cmd}, 32'h2);
        chk(cap_addr == 32'h0000_0CFD, "R6 io addr", cap_addr, 32'h0CFD);
        chk(cap_be == 4'b0010, "R6 lane", {28'b0, cap_be}, 32'h2);
        chk(rd == 32'h1234_5678, "R6 read data", rd, 32'h1234_5678);
        io_access(1, 16'h0080, 2, 32'h0BAD_F00D, rd);
        chk(cap_cmd == 4'b0011 && cap_addr == 32'h80, "R6 other address", cap_addr, 32'h80);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL R8 watchdog actual=%0d expected<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch();
        t_type1();
        t_type0();
        t_timeout();
        t_partial_latch();
        t_passthru();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule